// File: doc/BRIEF.md
# Gated CRC-16 Block Checker

This block checks the 16-bit cyclic redundancy code of a received block while letting a frame parser decide, byte by byte, which bytes take part. Fill characters, escape prefixes and other framing bytes can be left out of the sum; payload and the two trailing check bytes are folded in. The include decision for a byte is made one character late: every byte is first parked in a one-byte holding stage. It is folded into the code only when the next byte arrives and the include input is high in that same cycle. This gives the parser a full byte time to classify a character before committing it.

The parser marks the second check byte with a tail flag. Two accepted bytes later the block reports the residue as a pass/fail result in a status byte. It then returns itself to the cleared, empty state, ready for the next block. A clear input drops everything in flight at any time. The code uses the generator x^16 + x^15 + x^2 + 1, processed least significant bit first, starting from zero. A zero residue means a good block.

Top module: `bcc_gated_crc`

## Requirements
- R1: After reset, and in every cycle in which `res_vld_o` is low, `res_stat_o` is 8'h00 and `res_err_o` is low.
- R2: The code is the bit-reflected form of x^16+x^15+x^2+1 (reflected constant 16'hA001), data taken bit 0 first, starting value 16'h0000. A block whose included bytes are followed by its code, low byte first and then high byte (both included), reports `res_err_o` low and `res_stat_o` equal to 8'h80: bit 7 marks a finished block and bit 6 an error.
- R3: A byte accepted while `byte_vld_i` is high is folded into the code only if `incl_i` is high in the cycle that the next byte is accepted. The value of `incl_i` in the byte's own cycle applies to the previously held byte. The first byte after reset, clear or a result has no predecessor, so `incl_i` then has no effect.
- R4: A byte whose include decision is low leaves the code unchanged, so a block with excluded fill bytes between its included bytes still passes.
- R5: Any included byte that differs from the one the code was computed over makes `res_err_o` high and `res_stat_o` equal to 8'hC0.
- R6: `res_vld_o` is high for exactly one clock cycle. That cycle follows the clock edge that accepts the second byte after the byte presented with `tail_i` high. The residue judged is the code after the tail byte itself has been folded in, under the include decision given with the first following byte.
- R7: When a result is produced, the code returns to zero and the holding stage empties. The byte accepted at that edge is discarded, and the next block starts from nothing left over.
- R8: `clr_i` returns the code to zero, empties the holding stage and cancels a pending result. It takes priority over a byte presented in the same cycle, which is dropped, and no result follows the cleared tail.
- R9: `incl_i` has no effect in cycles where `byte_vld_i` is low.
- R10: Any number of idle cycles may separate bytes; the code holds its value across them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| byte_i | input | 8 | Received byte |
| byte_vld_i | input | 1 | `byte_i` carries a new byte this cycle |
| incl_i | input | 1 | Include decision for the byte received before the current one |
| tail_i | input | 1 | The current byte is the second check byte |
| clr_i | input | 1 | Drop all state and any pending result |
| res_vld_o | output | 1 | One-cycle result strobe |
| res_err_o | output | 1 | Residue was nonzero (valid with `res_vld_o`) |
| res_stat_o | output | 8 | Status byte: bit 7 finished, bit 6 error, other bits zero |

## Verification
The bound checker watches, on every cycle, the properties that need no knowledge of the byte stream. The result is a single-cycle pulse that only ever follows an accepted byte. The status byte reads zero outside that pulse. The code is zero after a clear and after each result, and it holds still across idle cycles. The value of the residue is a different matter. Whether the one-character lag of the include decision lines up with the bytes, whether excluded fill leaves the sum untouched, and whether a corrupted byte is caught all depend on concrete byte sequences. Only the bench's scenarios show these, by comparing with a code computed independently from the generator. The same holds for the exact timing of the result two bytes after the tail.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

  localparam int unsigned BCC_DAT_W    = 8;
  localparam int unsigned BCC_CRC_W    = 16;
  // x^16 + x^15 + x^2 + 1, bit-reversed for least-significant-bit-first shifting
  localparam logic [BCC_CRC_W-1:0] BCC_POLY_REFL = 16'hA001;
  localparam logic [BCC_CRC_W-1:0] BCC_CRC_INIT  = 16'h0000;
  // accepted bytes between the tail byte and the result
  localparam int unsigned BCC_RES_LAG  = 2;

  // status byte layout
  localparam int unsigned BCC_STAT_W    = 8;
  localparam int unsigned BCC_STAT_DONE = 7;
  localparam int unsigned BCC_STAT_ERR  = 6;

endpackage

// File: rtl/bcc_crc_step.sv
module bcc_crc_step
  import bcc_pkg::*;
#(
  parameter int unsigned            DAT_W = BCC_DAT_W,
  parameter int unsigned            CRC_W = BCC_CRC_W,
  parameter logic [CRC_W-1:0]       POLY  = BCC_POLY_REFL
) (
  input  logic [CRC_W-1:0] crc_i,
  input  logic [DAT_W-1:0] dat_i,
  output logic [CRC_W-1:0] crc_o
);

  // one full byte of a reflected shift register, bit 0 of the data first
  always_comb begin
    logic [CRC_W-1:0] acc;
    logic             fb;
    acc = crc_i;
    for (int b = 0; b < int'(DAT_W); b++) begin
      fb  = acc[0] ^ dat_i[b];
      acc = acc >> 1;
      if (fb) begin
        acc = acc ^ POLY;
      end
    end
    crc_o = acc;
  end

endmodule

// File: rtl/bcc_lag_stage.sv
module bcc_lag_stage
  import bcc_pkg::*;
#(
  parameter int unsigned DAT_W = BCC_DAT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drop_i,   // clear or end of block
  input  logic             take_i,   // a byte is accepted
  input  logic [DAT_W-1:0] dat_i,
  output logic [DAT_W-1:0] held_o,
  output logic             held_vld_o
);

  logic [DAT_W-1:0] held_q, held_d;
  logic             vld_q,  vld_d;
  logic             held_en;

  // next state
  always_comb begin
    held_en = take_i & ~drop_i;
    held_d  = dat_i;
    if (drop_i) begin
      vld_d = 1'b0;
    end else if (take_i) begin
      vld_d = 1'b1;
    end else begin
      vld_d = vld_q;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
    end else if (held_en) begin
      held_q <= held_d;
    end
  end

  assign held_o     = held_q;
  assign held_vld_o = vld_q;

endmodule

// File: rtl/bcc_tail_timer.sv
module bcc_tail_timer
  import bcc_pkg::*;
#(
  parameter int unsigned LAG   = BCC_RES_LAG,
  localparam int unsigned CNT_W = (LAG < 2) ? 1 : $clog2(LAG + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic step_i,   // a byte is accepted
  input  logic tail_i,   // that byte is the last check byte
  output logic fire_o    // this accepted byte completes the lag
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr_i | step_i;
    if (clr_i) begin
      cnt_d = '0;
    end else if (tail_i) begin
      cnt_d = CNT_W'(LAG);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
    end else begin
      cnt_d = '0;
    end
    fire_o = step_i & ~clr_i & (cnt_q == CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/bcc_gated_crc.sv
module bcc_gated_crc
  import bcc_pkg::*;
#(
  parameter int unsigned            DAT_W   = BCC_DAT_W,
  parameter int unsigned            CRC_W   = BCC_CRC_W,
  parameter logic [CRC_W-1:0]       POLY    = BCC_POLY_REFL,
  parameter logic [CRC_W-1:0]       INIT    = BCC_CRC_INIT,
  parameter int unsigned            RES_LAG = BCC_RES_LAG,
  parameter int unsigned            STAT_W  = BCC_STAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DAT_W-1:0]  byte_i,
  input  logic              byte_vld_i,
  input  logic              incl_i,
  input  logic              tail_i,
  input  logic              clr_i,
  output logic              res_vld_o,
  output logic              res_err_o,
  output logic [STAT_W-1:0] res_stat_o
);

  logic              take;
  logic              absorb;
  logic              fire;
  logic              drop;
  logic [DAT_W-1:0]  held;
  logic              held_vld;
  logic [CRC_W-1:0]  crc_q, crc_d, crc_step;
  logic              crc_en;
  logic              res_vld_q;
  logic              res_err_q, res_err_d;

  assign take   = byte_vld_i & ~clr_i;
  assign absorb = take & held_vld & incl_i;
  assign drop   = clr_i | fire;

  bcc_lag_stage #(.DAT_W(DAT_W)) u_lag (
    .clk        (clk),
    .rst_n      (rst_n),
    .drop_i     (drop),
    .take_i     (take),
    .dat_i      (byte_i),
    .held_o     (held),
    .held_vld_o (held_vld)
  );

  bcc_crc_step #(.DAT_W(DAT_W), .CRC_W(CRC_W), .POLY(POLY)) u_step (
    .crc_i (crc_q),
    .dat_i (held),
    .crc_o (crc_step)
  );

  bcc_tail_timer #(.LAG(RES_LAG)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr_i),
    .step_i (byte_vld_i),
    .tail_i (tail_i),
    .fire_o (fire)
  );

  // code register: next state
  always_comb begin
    crc_en = drop | absorb;
    if (drop) begin
      crc_d = INIT;
    end else begin
      crc_d = crc_step;
    end
    res_err_d = (crc_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= INIT;
    end else if (crc_en) begin
      crc_q <= crc_d;
    end
  end

  // result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld_q <= 1'b0;
    end else begin
      res_vld_q <= fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_err_q <= 1'b0;
    end else if (fire) begin
      res_err_q <= res_err_d;
    end
  end

  always_comb begin
    res_stat_o = '0;
    res_stat_o[BCC_STAT_DONE] = res_vld_q;
    res_stat_o[BCC_STAT_ERR]  = res_vld_q & res_err_q;
  end

  assign res_vld_o = res_vld_q;
  assign res_err_o = res_vld_q & res_err_q;

endmodule

// File: rtl/bcc_gated_crc_sva.sv
module bcc_gated_crc_sva #(
  parameter int unsigned CRC_W  = 16,
  parameter int unsigned STAT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              byte_vld_i,
  input logic              clr_i,
  input logic              res_vld_o,
  input logic              res_err_o,
  input logic [STAT_W-1:0] res_stat_o,
  input logic [CRC_W-1:0]  crc_q,
  input logic              held_vld
);

  AST_IDLE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld_o |-> (res_stat_o == '0) && !res_err_o);  // R1

  AST_RES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld_o |=> !res_vld_o);  // R6

  AST_RES_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld_o |-> $past(byte_vld_i) && !$past(clr_i));  // R6

  AST_TERM_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld_o |-> (crc_q == '0) && !held_vld);  // R7

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (crc_q == '0) && !held_vld && !res_vld_o);  // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_vld_i && !clr_i) |=> $stable(crc_q) && !res_vld_o);  // R10

endmodule

bind bcc_gated_crc bcc_gated_crc_sva #(.CRC_W(CRC_W), .STAT_W(STAT_W)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .byte_vld_i (byte_vld_i),
  .clr_i      (clr_i),
  .res_vld_o  (res_vld_o),
  .res_err_o  (res_err_o),
  .res_stat_o (res_stat_o),
  .crc_q      (crc_q),
  .held_vld   (held_vld)
);

// File: tb/bcc_gated_crc_bench.sv
module bcc_gated_crc_bench;

  logic       clk;
  logic       rst_n;
  logic [7:0] byte_i;
  logic       byte_vld_i;
  logic       incl_i;
  logic       tail_i;
  logic       clr_i;
  logic       res_vld_o;
  logic       res_err_o;
  logic [7:0] res_stat_o;

  int checks;
  int failures;
  bit done;

  logic [7:0] fd  [0:15];
  bit         fin [0:15];
  int         flen;

  logic       s_vld;
  logic       s_err;
  logic [7:0] s_stat;

  bcc_gated_crc u_bcc_gated_crc (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_i     (byte_i),
    .byte_vld_i (byte_vld_i),
    .incl_i     (incl_i),
    .tail_i     (tail_i),
    .clr_i      (clr_i),
    .res_vld_o  (res_vld_o),
    .res_err_o  (res_err_o),
    .res_stat_o (res_stat_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // reflected x^16+x^15+x^2+1, bit 0 first
  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 16'hA001;
      else             r = r >> 1;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] d, input bit inc, input bit tl, input bit clr);
    @(negedge clk);
    byte_i = d; byte_vld_i = 1'b1; incl_i = inc; tail_i = tl; clr_i = clr;
    @(negedge clk);
    byte_vld_i = 1'b0; incl_i = 1'b0; tail_i = 1'b0; clr_i = 1'b0;
    s_vld = res_vld_o; s_err = res_err_o; s_stat = res_stat_o;
  endtask

  task automatic idle_incl(input int n);
    incl_i = 1'b1;
    repeat (n) @(negedge clk);
    incl_i = 1'b0;
    s_vld = res_vld_o;
  endtask

  task automatic fnew();
    flen = 0;
  endtask

  task automatic fadd(input logic [7:0] d, input bit inc);
    fd[flen] = d; fin[flen] = inc; flen++;
  endtask

  task automatic fseal();
    logic [15:0] c;
    c = 16'h0000;
    for (int k = 0; k < flen; k++) if (fin[k]) c = ref_crc(c, fd[k]);
    fadd(c[7:0], 1'b1);
    fadd(c[15:8], 1'b1);
  endtask

  // lagged: include flag of byte k is driven with byte k+1 (R3)
  task automatic run_frame(input bit lagged, input bit gaps, input bit exp_err,
                           input string req);
    logic [7:0] exp_stat;
    for (int k = 0; k < flen; k++) begin
      bit inc;
      inc = lagged ? ((k > 0) ? fin[k-1] : 1'b0) : fin[k];
      put(fd[k], inc, (k == flen - 1), 1'b0);
      chk(s_vld == 1'b0, "R6", "no result before lag", s_vld, 0);
      if (gaps) begin
        idle_incl(3);
        chk(s_vld == 1'b0, "R9", "idle include no result", s_vld, 0);
      end
    end
    put(8'hFF, lagged ? fin[flen-1] : 1'b0, 1'b0, 1'b0);
    chk(s_vld == 1'b0, "R6", "no result after first fill", s_vld, 0);
    put(8'hFF, 1'b0, 1'b0, 1'b0);
    exp_stat = exp_err ? 8'hC0 : 8'h80;
    chk(s_vld == 1'b1, "R6", "result after second fill", s_vld, 1);
    chk(s_err == exp_err, req, "error flag", s_err, exp_err);
    chk(s_stat == exp_stat, req, "status byte", s_stat, exp_stat);
    @(negedge clk);
    chk(res_vld_o == 1'b0, "R6", "single cycle result", res_vld_o, 0);
  endtask

  task automatic t_reset();
    chk(res_vld_o == 1'b0, "R1", "reset valid", res_vld_o, 0);
    chk(res_stat_o == 8'h00, "R1", "reset status", res_stat_o, 0);
    chk(res_err_o == 1'b0, "R1", "reset error", res_err_o, 0);
  endtask

  task automatic t_good();
    fnew();
    fadd(8'h02, 1'b1); fadd(8'h48, 1'b1); fadd(8'h65, 1'b1);
    fadd(8'h6C, 1'b1); fadd(8'h03, 1'b1);
    fseal();
    run_frame(1'b1, 1'b0, 1'b0, "R2");
  endtask

  task automatic t_syn();
    fnew();
    fadd(8'h02, 1'b1); fadd(8'h16, 1'b0); fadd(8'h16, 1'b0);
    fadd(8'hA5, 1'b1); fadd(8'h10, 1'b0); fadd(8'h5A, 1'b1);
    fadd(8'h16, 1'b0); fadd(8'h17, 1'b1);
    fseal();
    run_frame(1'b1, 1'b0, 1'b0, "R4");
  endtask

  task automatic t_bad();
    fnew();
    fadd(8'h01, 1'b1); fadd(8'h33, 1'b1); fadd(8'h44, 1'b1); fadd(8'h03, 1'b1);
    fseal();
    fd[2] = 8'h45;
    run_frame(1'b1, 1'b0, 1'b1, "R5");
  endtask

  // flags aligned with the byte itself instead of one late
  task automatic t_lag();
    logic [15:0] c;
    fnew();
    fadd(8'h41, 1'b1); fadd(8'h16, 1'b0); fadd(8'h42, 1'b1);
    fseal();
    // per R3 the included bytes are those followed by a high flag
    c = 16'h0000;
    for (int k = 0; k < flen - 1; k++) if (fin[k+1]) c = ref_crc(c, fd[k]);
    run_frame(1'b0, 1'b0, (c != 16'h0000), "R3");
    chk(c != 16'h0000, "R3", "misaligned residue nonzero", c, 1);
  endtask

  task automatic t_back2back();
    fnew();
    fadd(8'h02, 1'b1); fadd(8'h77, 1'b1); fadd(8'h03, 1'b1);
    fseal();
    fd[1] = 8'h76;
    run_frame(1'b1, 1'b0, 1'b1, "R5");
    fd[1] = 8'h77;
    run_frame(1'b1, 1'b0, 1'b0, "R7");
  endtask

  task automatic t_clr();
    fnew();
    fadd(8'h02, 1'b1); fadd(8'h12, 1'b1); fadd(8'h03, 1'b1);
    fseal();
    for (int k = 0; k < flen; k++)
      put(fd[k], (k > 0) ? fin[k-1] : 1'b0, (k == flen - 1), 1'b0);
    put(8'hFF, 1'b1, 1'b0, 1'b0);
    put(8'hFF, 1'b0, 1'b0, 1'b1);
    chk(s_vld == 1'b0, "R8", "clear cancels result", s_vld, 0);
    put(8'hFF, 1'b0, 1'b0, 1'b0);
    chk(s_vld == 1'b0, "R8", "no late result 1", s_vld, 0);
    put(8'hFF, 1'b0, 1'b0, 1'b0);
    chk(s_vld == 1'b0, "R8", "no late result 2", s_vld, 0);
    // bytes after clear left a held byte; clear again, then a clean block
    put(8'h00, 1'b0, 1'b0, 1'b1);
    run_frame(1'b1, 1'b0, 1'b0, "R8");
  endtask

  task automatic t_idle();
    fnew();
    fadd(8'h02, 1'b1); fadd(8'h16, 1'b0); fadd(8'hC3, 1'b1);
    fadd(8'h16, 1'b0); fadd(8'h03, 1'b1);
    fseal();
    run_frame(1'b1, 1'b1, 1'b0, "R10");
  endtask

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    byte_i = '0; byte_vld_i = 1'b0; incl_i = 1'b0; tail_i = 1'b0; clr_i = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_good();
    t_syn();
    t_bad();
    t_lag();
    t_back2back();
    t_clr();
    t_idle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule